// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the digital host side of a data converter. A host processor reaches it over an asynchronous parallel bus. The bus has active-low chip select, read and write strobes and a 13-line data bus, carried as separate in, out and per-line output-enable vectors. Host writes land in a configuration register. That register picks the analog input channel, the read-back width, the direction of a conversion-sync pin, the read source and a standby request. A write can also carry a one-shot start command.

A counter stands in for the converter core. A conversion runs for `CONV_CYCLES` clocks, and at the end the word on `res_data_i` is captured as the result. A strap, sampled once after power-up reset, decides which write-strobe edge commits data. The strobes, chip select and the sync pin pass through two-stage synchronizers before their edges are used. The output enables and the input-enable flag follow the raw pins directly.

There is no streaming interface. The result word is sampled with no handshake, so no back-pressure can arise. The host paces itself with the ready flag, and all control and status pins are plain levels.

Top module: `adc_host_if`

## Requirements
- R1: After reset the configuration is all zeros. In that state `chan_sel_o` is 0, `sync_oe_o` is 1, `sync_o` is 0, `stby_n_o` is 1, `rdy_n_o` is 0, and `data_oe_o` and `din_en_o` are 0.
- R2: `mode_strap_i` is captured on the first clock after reset. If it was 0, a write commits on the rising edge of the write strobe. If it was 1, a write commits on the falling edge. In both cases chip select must be low at that edge.
- R3: A change on `mode_strap_i` after that first clock has no effect on which strobe edge commits a write.
- R4: `din_en_o` is 1 exactly while both `cs_n_i` and `wr_n_i` are low.
- R5: `data_oe_o` is 0 unless both `cs_n_i` and `rd_n_i` are low. During a read, lines 7..0 are always enabled. Lines 12..8 are enabled only when config bit 12 (width) is 1. A disabled line reads as 0 on `data_o`.
- R6: When config bit 10 is 0, a read returns the configuration word. That word has bit 12 = width, bit 11 = standby request, bit 10 = read source, bit 8 = sync direction and bits 3..0 = channel. Bits 9 and 7..4 read as 0.
- R7: `chan_sel_o` shows config bits 3..0.
- R8: With config bit 8 = 0 (sync pin is an output), a write with bit 9 set starts a conversion. `sync_oe_o` is 1, and `sync_o` is high for exactly `CONV_CYCLES` clocks. `conv_start_o` and `conv_done_o` each pulse once. A start request made while a conversion is running is ignored.
- R9: With config bit 8 = 1 (sync pin is an input), `sync_oe_o` is 0 and `sync_o` stays 0. A rising edge on `sync_i` starts a conversion, and a write with bit 9 set starts nothing.
- R10: At the end of a conversion, `res_data_i` is captured. With config bit 10 = 1, a read returns that captured word. Later changes on `res_data_i` do not alter it.
- R11: `rdy_n_o` is low only when the block is awake and idle. It is high for each of the `CONV_CYCLES` conversion clocks.
- R12: Setting config bit 11 enters standby, but only once no conversion is running. While in standby, `stby_n_o` is 0, `rdy_n_o` is 1 and start requests are ignored. `stby_n_o` goes high as soon as the request is cleared, and `rdy_n_o` stays high for `WAKE_CYCLES` clocks after that before dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| mode_strap_i | input | 1 | Write-edge strap, sampled once after reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| data_i | input | 13 | Data bus, input side |
| data_o | output | 13 | Data bus, output side |
| data_oe_o | output | 13 | Per-line output enable of the data bus |
| din_en_o | output | 1 | Data input buffers enabled |
| sync_i | input | 1 | Sync pin, input side |
| sync_o | output | 1 | Sync pin, output side (conversion busy) |
| sync_oe_o | output | 1 | Sync pin output enable |
| chan_sel_o | output | 4 | Analog channel select |
| rdy_n_o | output | 1 | Ready, active low |
| stby_n_o | output | 1 | Standby status, low while in standby |
| conv_start_o | output | 1 | One-clock start pulse to the converter core |
| conv_done_o | output | 1 | One-clock completion pulse |
| res_data_i | input | 13 | Conversion result word from the core |

## Verification
Two functions can collide in one clock: a standby request, and a conversion that is still running or has just been started. The bench starts a conversion, waits until the sync output shows it busy, and then writes the standby request into the middle of it. It passes if the conversion completes once with its full length, and if `stby_n_o` stays high until completion and only falls afterwards. A second start command, written while the first conversion is still running, exercises the overlap between a new request and a busy converter. It passes if exactly one start pulse is counted.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int DW     = 13;
  localparam int NARROW = 8;
  localparam int CHW    = 4;

  localparam int B_SYNCDIR = 8;
  localparam int B_START   = 9;
  localparam int B_RDSEL   = 10;
  localparam int B_STBY    = 11;
  localparam int B_WIDTH   = 12;

  typedef struct packed {
    logic           wide;
    logic           stby_req;
    logic           rd_res;
    logic           sync_in_mode;
    logic [CHW-1:0] chan;
  } cfg_t;

  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_SLEEP = 2'd1,
    PW_WAKE  = 2'd2
  } pwr_e;
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_i,
  input  logic          cs_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          cs_s,
  input  logic          wr_s,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] res_i,
  output cfg_t          cfg_o,
  output logic          start_cmd_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] data_oe_o,
  output logic          din_en_o
);
  logic strap_q, strap_taken, wr_q;
  logic wr_rise, wr_fall, commit;
  logic rd_en;
  cfg_t cfg_q;
  logic start_q;
  logic [DW-1:0] cfg_word, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q     <= 1'b0;
      strap_taken <= 1'b0;
      wr_q        <= 1'b1;
    end else begin
      wr_q <= wr_s;
      if (!strap_taken) begin
        strap_q     <= strap_i;
        strap_taken <= 1'b1;
      end
    end
  end

  assign wr_rise = wr_s & ~wr_q;
  assign wr_fall = ~wr_s & wr_q;
  assign commit  = strap_taken & ~cs_s & (strap_q ? wr_fall : wr_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= commit & data_i[B_START];
      if (commit) begin
        cfg_q.wide         <= data_i[B_WIDTH];
        cfg_q.stby_req     <= data_i[B_STBY];
        cfg_q.rd_res       <= data_i[B_RDSEL];
        cfg_q.sync_in_mode <= data_i[B_SYNCDIR];
        cfg_q.chan         <= data_i[CHW-1:0];
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign start_cmd_o = start_q;

  always_comb begin
    cfg_word            = '0;
    cfg_word[B_WIDTH]   = cfg_q.wide;
    cfg_word[B_STBY]    = cfg_q.stby_req;
    cfg_word[B_RDSEL]   = cfg_q.rd_res;
    cfg_word[B_SYNCDIR] = cfg_q.sync_in_mode;
    cfg_word[CHW-1:0]   = cfg_q.chan;
  end

  assign rd_word  = cfg_q.rd_res ? res_i : cfg_word;
  assign rd_en    = ~cs_n_i & ~rd_n_i;
  assign din_en_o = ~cs_n_i & ~wr_n_i;

  for (genvar g = 0; g < DW; g++) begin : g_lane
    if (g < NARROW) begin : g_low
      assign data_oe_o[g] = rd_en;
    end else begin : g_high
      assign data_oe_o[g] = rd_en & cfg_q.wide;
    end
    assign data_o[g] = data_oe_o[g] & rd_word[g];
  end

  // R5
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |-> (data_oe_o == '0));
  // R5
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.wide |-> (data_oe_o[DW-1:NARROW] == '0));
  // R3
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_taken && $past(strap_taken)) |-> $stable(strap_q));
  // R2
  no_commit_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !start_q);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_host_pkg::*;
#(
  parameter int CONV_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_in_mode,
  input  logic          start_cmd,
  input  logic          sync_s,
  input  logic          run_ok,
  input  logic [DW-1:0] res_i,
  output logic          conv_start_o,
  output logic          conv_done_o,
  output logic          busy_o,
  output logic [DW-1:0] result_o,
  output logic          sync_o,
  output logic          sync_oe_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic          sync_q, sync_rise, req;
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] res_q;

  assign sync_rise    = sync_s & ~sync_q;
  assign req          = sync_in_mode ? sync_rise : start_cmd;
  assign conv_start_o = req & run_ok & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else begin
      sync_q <= sync_s;
      done_q <= 1'b0;
      if (conv_start_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(CONV_CYCLES);
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= res_i;
        end
      end
    end
  end

  assign conv_done_o = done_q;
  assign busy_o      = busy_q;
  assign result_o    = res_q;
  assign sync_oe_o   = ~sync_in_mode;
  assign sync_o      = busy_q & ~sync_in_mode;

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> !busy_q);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> busy_q);
  // R10
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> conv_done_o);
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_host_pkg::*;
#(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_req,
  input  logic busy,
  input  logic conv_start,
  output logic run_ok,
  output logic stby_n_o,
  output logic rdy_n_o
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  pwr_e          st_q;
  logic [WW-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PW_RUN;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        PW_RUN: if (stby_req && !busy && !conv_start) st_q <= PW_SLEEP;
        PW_SLEEP: if (!stby_req) begin
          st_q   <= PW_WAKE;
          wcnt_q <= WW'(WAKE_CYCLES);
        end
        PW_WAKE: begin
          wcnt_q <= wcnt_q - 1'b1;
          if (stby_req) st_q <= PW_SLEEP;
          else if (wcnt_q == WW'(1)) st_q <= PW_RUN;
        end
        default: st_q <= PW_RUN;
      endcase
    end
  end

  assign run_ok   = (st_q == PW_RUN);
  assign stby_n_o = !((st_q == PW_SLEEP) && stby_req);
  assign rdy_n_o  = !((st_q == PW_RUN) && !busy);

  // R12
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PW_SLEEP) |-> !busy);
  // R11
  start_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> rdy_n_o);
  // R12
  stby_flag_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n_o |-> (!run_ok && rdy_n_o));
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int CONV_CYCLES = 40,
  parameter int WAKE_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_strap_i,
  input  logic           cs_n_i,
  input  logic           rd_n_i,
  input  logic           wr_n_i,
  input  logic [DW-1:0]  data_i,
  output logic [DW-1:0]  data_o,
  output logic [DW-1:0]  data_oe_o,
  output logic           din_en_o,
  input  logic           sync_i,
  output logic           sync_o,
  output logic           sync_oe_o,
  output logic [CHW-1:0] chan_sel_o,
  output logic           rdy_n_o,
  output logic           stby_n_o,
  output logic           conv_start_o,
  output logic           conv_done_o,
  input  logic [DW-1:0]  res_data_i
);
  logic [1:0]    strb_s;
  logic          sync_s;
  cfg_t          cfg;
  logic          start_cmd, busy, run_ok, conv_start;
  logic [DW-1:0] result;

  adc_in_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n_i, wr_n_i}), .q(strb_s)
  );

  adc_in_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_i), .q(sync_s)
  );

  adc_host_port u_port (
    .clk(clk), .rst_n(rst_n), .strap_i(mode_strap_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .cs_s(strb_s[1]), .wr_s(strb_s[0]),
    .data_i(data_i), .res_i(result),
    .cfg_o(cfg), .start_cmd_o(start_cmd),
    .data_o(data_o), .data_oe_o(data_oe_o), .din_en_o(din_en_o)
  );

  adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync_in_mode(cfg.sync_in_mode),
    .start_cmd(start_cmd), .sync_s(sync_s), .run_ok(run_ok),
    .res_i(res_data_i), .conv_start_o(conv_start), .conv_done_o(conv_done_o),
    .busy_o(busy), .result_o(result), .sync_o(sync_o), .sync_oe_o(sync_oe_o)
  );

  adc_pwr_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .stby_req(cfg.stby_req), .busy(busy),
    .conv_start(conv_start), .run_ok(run_ok),
    .stby_n_o(stby_n_o), .rdy_n_o(rdy_n_o)
  );

  assign conv_start_o = conv_start;
  assign chan_sel_o   = cfg.chan;

  // R9
  sync_in_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe_o |-> !sync_o);
  // R8
  sync_busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> rdy_n_o);
endmodule

// File: tb/sim_adc_host_if.sv
`timescale 1ns/1ps
module sim_adc_host_if;
  localparam int CONV = 40;
  localparam int WAKE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [12:0] din = '0;
  logic [12:0] dout, doe;
  logic din_en, sync_in = 1'b0, sync_out, sync_oe;
  logic [3:0] chan;
  logic rdy_n, stby_n, cstart, cdone;
  logic [12:0] res = 13'h1ABC;

  int n_chk = 0, n_bad = 0;
  int n_start = 0, n_done = 0, n_synchi = 0, n_rdyhi = 0;

  always #10 clk = ~clk;

  adc_host_if #(.CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_strap_i(strap),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .data_i(din), .data_o(dout), .data_oe_o(doe), .din_en_o(din_en),
    .sync_i(sync_in), .sync_o(sync_out), .sync_oe_o(sync_oe),
    .chan_sel_o(chan), .rdy_n_o(rdy_n), .stby_n_o(stby_n),
    .conv_start_o(cstart), .conv_done_o(cdone), .res_data_i(res)
  );

  always @(negedge clk) begin
    if (cstart) n_start++;
    if (cdone) n_done++;
    if (sync_out) n_synchi++;
    if (rdy_n) n_rdyhi++;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; cs_n = 1; rd_n = 1; wr_n = 1; sync_in = 0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic bus_write(input logic [12:0] v);
    @(negedge clk);
    din = v; cs_n = 0;
    cyc(2); wr_n = 0;
    cyc(6); wr_n = 1;
    cyc(6); cs_n = 1;
    cyc(2);
  endtask

  task automatic bus_read(input string req, input logic [12:0] ed, input logic [12:0] eo);
    @(negedge clk);
    cs_n = 0; rd_n = 0;
    cyc(1);
    chk(req, "read enables", doe, eo);
    chk(req, "read data", dout, ed);
    rd_n = 1; cs_n = 1;
    cyc(1);
    chk(req, "enables after read", doe, 0);
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    chk("R1", "chan", chan, 0);
    chk("R1", "sync_oe", sync_oe, 1);
    chk("R1", "sync_out", sync_out, 0);
    chk("R1", "stby_n", stby_n, 1);
    chk("R1", "rdy_n", rdy_n, 0);
    chk("R1", "oe idle", doe, 0);
    chk("R1", "din_en idle", din_en, 0);
    bus_read("R1", 13'h0000, 13'h00FF);
  endtask

  task automatic t_rise_latch;
    strap = 1'b1; // R3: late strap change
    @(negedge clk);
    din = 13'h0005; cs_n = 0;
    cyc(2); wr_n = 0;
    cyc(6);
    chk("R4", "din_en while cs,wr low", din_en, 1);
    chk("R2", "no commit before rising edge", chan, 0);
    chk("R3", "late strap ignored", chan, 0);
    wr_n = 1;
    cyc(6);
    chk("R4", "din_en with wr high", din_en, 0);
    chk("R2", "commit on rising edge", chan, 5);
    chk("R7", "chan_sel", chan, 5);
    cs_n = 1;
    cyc(2);
  endtask

  task automatic t_fall_latch;
    do_reset(1'b1);
    strap = 1'b0;
    @(negedge clk);
    din = 13'h000A; cs_n = 0;
    cyc(2); wr_n = 0;
    cyc(6);
    chk("R2", "commit on falling edge", chan, 4'hA);
    din = 13'h0003;
    cyc(2); wr_n = 1;
    cyc(6);
    chk("R2", "rising edge ignored in falling mode", chan, 4'hA);
    cs_n = 1;
    cyc(2);
    do_reset(1'b0);
  endtask

  task automatic t_width_read;
    bus_write(13'h0001);
    bus_read("R5", 13'h0001, 13'h00FF);
    bus_write(13'h10F3);
    bus_read("R6", 13'h1003, 13'h1FFF);
    @(negedge clk);
    rd_n = 0;
    cyc(1);
    chk("R5", "rd low with cs high", doe, 0);
    rd_n = 1;
    cyc(1);
  endtask

  task automatic t_out_conv;
    int s0, d0, h0, r0;
    bus_write(13'h1000);
    chk("R8", "sync_oe output mode", sync_oe, 1);
    s0 = n_start; d0 = n_done; h0 = n_synchi; r0 = n_rdyhi;
    bus_write(13'h1200);
    bus_write(13'h1200); // R8: second start while busy
    cyc(CONV);
    chk("R8", "start pulses", n_start - s0, 1);
    chk("R8", "done pulses", n_done - d0, 1);
    chk("R8", "sync_out high cycles", n_synchi - h0, CONV);
    chk("R11", "rdy_n high cycles", n_rdyhi - r0, CONV);
    chk("R11", "rdy_n idle", rdy_n, 0);
    bus_write(13'h1400);
    res = 13'h0155;
    bus_read("R10", 13'h1ABC, 13'h1FFF);
    bus_write(13'h1000);
    bus_read("R6", 13'h1000, 13'h1FFF);
  endtask

  task automatic t_in_conv;
    int s0, h0, r0;
    bus_write(13'h1100);
    chk("R9", "sync_oe input mode", sync_oe, 0);
    s0 = n_start; h0 = n_synchi;
    bus_write(13'h1300);
    cyc(4);
    chk("R9", "write start ignored", n_start - s0, 0);
    r0 = n_rdyhi;
    @(negedge clk);
    sync_in = 1'b1;
    cyc(CONV + 8);
    chk("R9", "sync edge starts", n_start - s0, 1);
    chk("R9", "sync_out quiet", n_synchi - h0, 0);
    chk("R11", "rdy_n high cycles", n_rdyhi - r0, CONV);
    sync_in = 1'b0;
    cyc(4);
  endtask

  task automatic t_standby;
    int s0;
    bus_write(13'h1800);
    cyc(2);
    chk("R12", "stby_n in standby", stby_n, 0);
    chk("R11", "rdy_n in standby", rdy_n, 1);
    s0 = n_start;
    bus_write(13'h1A00);
    cyc(CONV);
    chk("R12", "start ignored in standby", n_start - s0, 0);
    @(negedge clk);
    din = 13'h1000; cs_n = 0;
    cyc(2); wr_n = 0;
    cyc(2); wr_n = 1;
    for (int i = 0; i < 20 && stby_n == 1'b0; i++) @(negedge clk);
    chk("R12", "stby_n rises on clear", stby_n, 1);
    chk("R12", "rdy_n still high at wake", rdy_n, 1);
    cyc(WAKE - 1);
    chk("R12", "rdy_n high during wake", rdy_n, 1);
    cyc(4);
    chk("R12", "rdy_n low after wake", rdy_n, 0);
    cs_n = 1;
    cyc(2);
  endtask

  task automatic t_overlap;
    int d0;
    d0 = n_done;
    bus_write(13'h1200);
    for (int i = 0; i < 20 && sync_out == 1'b0; i++) @(negedge clk);
    bus_write(13'h1800);
    chk("R12", "still converting", sync_out, 1);
    chk("R12", "stby_n held during conversion", stby_n, 1);
    chk("R12", "no early done", n_done - d0, 0);
    cyc(CONV);
    chk("R12", "conversion completes", n_done - d0, 1);
    chk("R12", "standby after completion", stby_n, 0);
    bus_write(13'h1000);
    cyc(WAKE + 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_rise_latch();
    t_fall_latch();
    t_width_read();
    t_out_conv();
    t_in_conv();
    t_standby();
    t_overlap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule